// File: doc/BRIEF.md
# Multi-target interrupt mask aggregator

The aggregator receives a shared vector of 64 already-conditioned interrupt requests. It drives three independent active-high level interrupt outputs toward a parent controller. Each output belongs to a target, and each target masks the full request vector on its own. A target keeps a per-line enable bit and a per-line sticky software-trigger bit. Both are updated atomically through separate set and clear registers, so one target's configuration never disturbs another's.

Every target window is split into two banks of 32 lines. The lower bank covers lines 0..31. The upper bank covers lines 32..63 and sits 0x18 above the lower bank. Software reads a raw view (request OR software trigger) and a masked view (raw AND enable). A target's output goes high when any masked bit is set in either bank. During bring-up, software writes all-ones to each clear register to silence every line.

Access uses a single-cycle port. A write is applied at the clock edge while `we_i` is high. Read data is combinational from `addr_i`.

Top module: `irq_aggr_top`

## Requirements
- R1: After reset, all enable and software-trigger bits are zero, every `irq_o` bit is low, and every register reads zero while the requests are low.
- R2: A write to enable-set (bank offset 0x08) turns on the enables whose data bits are one and leaves the others unchanged.
- R3: A write to enable-clear (bank offset 0x0C) turns off the enables whose data bits are one and leaves the others unchanged.
- R4: A write to trigger-set (0x10) sets software-trigger bits, and a write to trigger-clear (0x14) clears them. Otherwise they hold indefinitely.
- R5: Raw status (offset 0x04) reads as request OR software-trigger for the bank's 32 lines.
- R6: Masked status (offset 0x00) reads as raw status AND enable.
- R7: `irq_o[t]` is registered. At each clock edge it takes the OR of target t's masked bits across both banks, as they stood before that edge.
- R8: The lower bank (offsets 0x00..0x14) serves lines 0..31. The upper bank (offsets 0x18..0x2C) serves lines 32..63, with bit n holding line 32+n.
- R9: Targets 0, 1 and 2 own the windows at 0x000, 0x100 and 0x300 (address bits [9:8] = 0, 1, 3). A write to one target changes no other target's state or output.
- R10: Window 0x200, window offsets 0x30..0xFF and non-word-aligned addresses read zero, and writes to them change nothing.
- R11: Reads of enable-set and enable-clear both return the current enables. Reads of trigger-set and trigger-clear both return the current software-trigger bits.
- R12: Writes to the raw and masked status offsets change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 64 | Conditioned interrupt requests, one per line |
| addr_i | input | 10 | Byte address of the register access |
| we_i | input | 1 | Write strobe, applied at the clock edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| irq_o | output | 3 | Level interrupt output of each target |

## Verification
A register write and a change on the request lines can land in the same cycle. The case of interest is an enable-clear that coincides with the rising edge of the very line it disables. The bench drives the request rise and the enable-clear write on the same falling edge. It then expects the target output to pulse high for exactly one cycle, because the output is computed from the pre-edge enables, and to fall on the following edge. A cycle-accurate behavioural model judges this case and the mixed random traffic of writes and request changes that follows, on every clock.

// File: rtl/irq_aggr_pkg.sv
`timescale 1ns/1ps
package irq_aggr_pkg;
  localparam int BANK_W      = 32;
  localparam int BANK_STRIDE = 'h18;
  localparam int WIN_SHIFT   = 8;

  typedef enum logic [2:0] {
    REG_MASKED = 3'd0,
    REG_RAW    = 3'd1,
    REG_EN_SET = 3'd2,
    REG_EN_CLR = 3'd3,
    REG_SW_SET = 3'd4,
    REG_SW_CLR = 3'd5
  } bank_reg_e;

  // window 2 is left to the trigger conditioner
  function automatic int win_of_target(int t);
    return (t < 2) ? t : t + 1;
  endfunction
endpackage

// File: rtl/irq_aggr_bank.sv
`timescale 1ns/1ps
module irq_aggr_bank
  import irq_aggr_pkg::*;
#(
  parameter int LINES = BANK_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] req_i,
  input  logic             acc_i,
  input  bank_reg_e        reg_i,
  input  logic             we_i,
  input  logic [LINES-1:0] wdata_i,
  output logic [LINES-1:0] rdata_o,
  output logic [LINES-1:0] masked_o
);
  logic [LINES-1:0] en_q, sw_q, raw;
  logic wr;

  assign wr       = acc_i & we_i;
  assign raw      = req_i | sw_q;
  assign masked_o = raw & en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
      sw_q <= '0;
    end else if (wr) begin
      case (reg_i)
        REG_EN_SET: en_q <= en_q | wdata_i;
        REG_EN_CLR: en_q <= en_q & ~wdata_i;
        REG_SW_SET: sw_q <= sw_q | wdata_i;
        REG_SW_CLR: sw_q <= sw_q & ~wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    if (acc_i) begin
      case (reg_i)
        REG_MASKED:            rdata_o = masked_o;
        REG_RAW:               rdata_o = raw;
        REG_EN_SET, REG_EN_CLR: rdata_o = en_q;
        REG_SW_SET, REG_SW_CLR: rdata_o = sw_q;
        default:               rdata_o = '0;
      endcase
    end
  end

  a_r2_en_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && reg_i == REG_EN_SET) |=> ((en_q & $past(wdata_i)) == $past(wdata_i)));
  a_r3_en_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && reg_i == REG_EN_CLR) |=> ((en_q & $past(wdata_i)) == '0));
  a_r4_sw_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && (reg_i == REG_SW_SET || reg_i == REG_SW_CLR)) |=> $stable(sw_q));
  a_r12_status_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && (reg_i == REG_RAW || reg_i == REG_MASKED)) |=> ($stable(en_q) && $stable(sw_q)));
endmodule

// File: rtl/irq_aggr_target.sv
`timescale 1ns/1ps
module irq_aggr_target
  import irq_aggr_pkg::*;
#(
  parameter int LINES  = 64,
  parameter int ADDR_W = 10,
  parameter int WIN    = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINES-1:0]  req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [BANK_W-1:0] wdata_i,
  output logic [BANK_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int N_BANK = LINES / BANK_W;
  localparam int WIN_W  = ADDR_W - WIN_SHIFT;

  logic              win_hit;
  logic [7:0]        off;
  logic [BANK_W-1:0] rdata_b  [N_BANK];
  logic [BANK_W-1:0] masked_b [N_BANK];
  logic              any_masked;
  logic              irq_q;

  assign win_hit = (addr_i[ADDR_W-1:WIN_SHIFT] == WIN_W'(WIN)) && (addr_i[1:0] == 2'b00);
  assign off     = addr_i[7:0];

  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    localparam logic [8:0] LO = 9'(b * BANK_STRIDE);
    localparam logic [8:0] HI = 9'((b + 1) * BANK_STRIDE);
    logic      acc;
    bank_reg_e sel;
    assign acc = win_hit && ({1'b0, off} >= LO) && ({1'b0, off} < HI);
    assign sel = bank_reg_e'(3'(({1'b0, off} - LO) >> 2));
    irq_aggr_bank #(.LINES(BANK_W)) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .req_i    (req_i[b*BANK_W +: BANK_W]),
      .acc_i    (acc),
      .reg_i    (sel),
      .we_i     (we_i),
      .wdata_i  (wdata_i),
      .rdata_o  (rdata_b[b]),
      .masked_o (masked_b[b])
    );
  end

  always_comb begin
    rdata_o    = '0;
    any_masked = 1'b0;
    for (int b = 0; b < N_BANK; b++) begin
      rdata_o    = rdata_o | rdata_b[b];
      any_masked = any_masked | (|masked_b[b]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= any_masked;
  end
  assign irq_o = irq_q;

  a_r7_irq_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(|(masked_b[0] | masked_b[N_BANK-1]))));
  a_r10_foreign_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_hit |-> (rdata_o == '0));
endmodule

// File: rtl/irq_aggr_top.sv
`timescale 1ns/1ps
module irq_aggr_top
  import irq_aggr_pkg::*;
#(
  parameter int LINES  = 64,
  parameter int N_TGT  = 3,
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINES-1:0]  req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [N_TGT-1:0]  irq_o
);
  localparam int WIN_W = ADDR_W - WIN_SHIFT;

  logic [BANK_W-1:0] rdata_t [N_TGT];

  for (genvar t = 0; t < N_TGT; t++) begin : g_tgt
    irq_aggr_target #(
      .LINES (LINES),
      .ADDR_W(ADDR_W),
      .WIN   (win_of_target(t))
    ) u_tgt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_i   (req_i),
      .addr_i  (addr_i),
      .we_i    (we_i),
      .wdata_i (wdata_i),
      .rdata_o (rdata_t[t]),
      .irq_o   (irq_o[t])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int t = 0; t < N_TGT; t++) rdata_o = rdata_o | rdata_t[t];
  end

  a_r10_reserved_win: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[ADDR_W-1:WIN_SHIFT] == WIN_W'(2)) |-> (rdata_o == '0));
  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (irq_o == '0));
endmodule

// File: tb/tb_irq_aggr_top.sv
`timescale 1ns/1ps
module tb_irq_aggr_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] req = '0;
  logic [9:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  irq;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;  // 50 MHz

  irq_aggr_top dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr),
    .we_i(we), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference
  logic [63:0] en_m [3];
  logic [63:0] sw_m [3];
  logic [2:0]  irq_m;

  function automatic int tgt_of(logic [1:0] w);
    case (w)
      2'd0: return 0;
      2'd1: return 1;
      2'd3: return 2;
      default: return -1;
    endcase
  endfunction

  function automatic int reg_of(logic [9:0] a);
    int o = int'(a[7:0]);
    if (tgt_of(a[9:8]) < 0 || a[1:0] != 0 || o >= 48) return -1;
    return (o % 24) / 4;
  endfunction

  function automatic logic [31:0] mread(logic [9:0] a);
    int t = tgt_of(a[9:8]);
    int r = reg_of(a);
    int sh = (int'(a[7:0]) >= 24) ? 32 : 0;
    logic [63:0] raw;
    logic [63:0] v;
    if (r < 0) return '0;
    raw = req | sw_m[t];
    case (r)
      0: v = raw & en_m[t];
      1: v = raw;
      2, 3: v = en_m[t];
      default: v = sw_m[t];
    endcase
    return 32'(v >> sh);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < 3; t++) begin en_m[t] <= '0; sw_m[t] <= '0; end
      irq_m <= '0;
    end else begin
      int t, r;
      logic [63:0] m;
      for (int k = 0; k < 3; k++) irq_m[k] <= |((req | sw_m[k]) & en_m[k]);
      t = tgt_of(addr[9:8]);
      r = reg_of(addr);
      if (we && r >= 2) begin
        m = {32'b0, wdata} << ((int'(addr[7:0]) >= 24) ? 32 : 0);
        case (r)
          2: en_m[t] <= en_m[t] | m;
          3: en_m[t] <= en_m[t] & ~m;
          4: sw_m[t] <= sw_m[t] | m;
          default: sw_m[t] <= sw_m[t] & ~m;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (addr %h, t=%0t)", tag, act, exp, addr, $time);
    end
  endtask

  // compare against the model on every clock
  always @(posedge clk) begin
    #5;
    if (!rst_n) begin
      chk("R1", 64'(irq), 64'(0));
      chk("R1", 64'(rdata), 64'(0));
    end else begin
      string tag;
      case (reg_of(addr))
        -1: tag = "R10";
        0: tag = "R6";
        1: tag = "R5";
        default: tag = "R11";
      endcase
      chk("R7", 64'(irq), 64'(irq_m));
      chk(tag, 64'(rdata), 64'(mread(addr)));
    end
  end

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, input logic [31:0] exp, input string tag);
    addr = a; we = 1'b0;
    #1;
    chk(tag, 64'(rdata), 64'(exp));
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rd(10'h008, 0, "R1"); rd(10'h328, 0, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", 64'(irq), 0);

    // R2 / R3 / R11 on target 0 lower bank
    wr(10'h008, 32'h0000_00F0);
    wr(10'h008, 32'h0000_0001);
    rd(10'h008, 32'hF1, "R2");
    rd(10'h00C, 32'hF1, "R11");
    wr(10'h00C, 32'h0000_0010);
    rd(10'h008, 32'hE1, "R3");

    // R4 / R5 / R6 / R7 via soft trigger on line 5
    wr(10'h010, 32'h20);
    chk("R7", 64'(irq[0]), 0);   // registered: not yet
    @(negedge clk);
    chk("R7", 64'(irq[0]), 1);
    rd(10'h004, 32'h20, "R5");
    rd(10'h000, 32'h20, "R6");
    rd(10'h014, 32'h20, "R4");
    repeat (5) @(negedge clk);
    rd(10'h010, 32'h20, "R4");
    wr(10'h014, 32'h20);
    rd(10'h014, 0, "R4");
    chk("R7", 64'(irq[0]), 1);
    @(negedge clk);
    chk("R7", 64'(irq[0]), 0);

    // R8: upper bank serves line 32
    req[32] = 1'b1;
    wr(10'h020, 32'h1);
    rd(10'h018, 32'h1, "R8");
    rd(10'h000, 32'h0, "R8");
    @(negedge clk);
    chk("R8", 64'(irq), 64'(3'b001));

    // R9: target 2 at 0x300, target 1 untouched
    wr(10'h320, 32'h1);
    @(negedge clk);
    chk("R9", 64'(irq), 64'(3'b101));
    rd(10'h120, 0, "R9");

    // R12: status writes ignored
    wr(10'h104, 32'hFFFF_FFFF);
    wr(10'h100, 32'hFFFF_FFFF);
    rd(10'h108, 0, "R12");
    rd(10'h110, 0, "R12");

    // R10: reserved window, high offsets, misaligned
    wr(10'h208, 32'hFFFF_FFFF);
    wr(10'h130, 32'hFFFF_FFFF);
    wr(10'h109, 32'hFFFF_FFFF);
    rd(10'h208, 0, "R10");
    rd(10'h200, 0, "R10");
    rd(10'h030, 0, "R10");
    rd(10'h00A, 0, "R10");
    rd(10'h108, 0, "R10");

    // same cycle: line 3 rises while its enable is cleared on target 1
    wr(10'h108, 32'h8);
    @(negedge clk);
    req[3] = 1'b1; addr = 10'h10C; wdata = 32'h8; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    chk("R3", 64'(irq[1]), 1);
    @(negedge clk);
    chk("R3", 64'(irq[1]), 0);

    // random traffic, checked by the per-cycle model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      req   = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      addr  = {2'($urandom), 2'b00, 4'($urandom % 12), 2'b00};
      if ($urandom % 16 == 0) addr = 10'($urandom);
      wdata = $urandom;
      we    = ($urandom % 2) == 0;
    end
    @(negedge clk);
    we = 1'b0;

    // bring-up style disable of everything
    req = '0;
    for (int t = 0; t < 4; t++) begin
      if (t == 2) continue;
      wr(10'(t * 256 + 'h0C), 32'hFFFF_FFFF);
      wr(10'(t * 256 + 'h24), 32'hFFFF_FFFF);
      wr(10'(t * 256 + 'h14), 32'hFFFF_FFFF);
      wr(10'(t * 256 + 'h2C), 32'hFFFF_FFFF);
    end
    repeat (2) @(negedge clk);
    chk("R3", 64'(irq), 0);
    rd(10'h324, 0, "R3");

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule